// File: doc/BRIEF.md
# Debug-Port DMA Access Sequencer

This block is a hardware master that carries out one memory read or write on a target through the DMA facility of a JTAG debug port. A client hands it an address, a transfer size (byte, halfword or word), a direction and, for writes, a data value. The block then issues a fixed series of abstract scan requests toward a separate TAP driver. Each request either selects a debug register (address, data or control) or shifts a 32-bit value through the register that is currently selected. Shifting at the bit level stays inside that driver. Each scan is a level request that the driver completes with a one-cycle acknowledge, which carries the 32 bits captured during the shift.

Once the access has been started, the block polls the control register until the start flag drops. It then reads back the error flag. When the error flag is set, the whole access is replayed from the address phase, up to a parameterised number of extra attempts. A poll that runs past a cycle limit ends the access with a timeout status. Write data is replicated across the byte lanes that belong to the size. Read data is steered down from the lane that the low address bits pick. The block handles one access at a time. A multi-element transfer is a series of single requests, with the address stepped by the element size.

Top module: `dbg_dma_seq`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `scan_req` is 0.
- R2: A write issues these scans in this order: select address register, shift the address, select data register, shift the lane-replicated data, select control register, then shift the start word. The start word is CTRL_BASE with bit 17 (access enable) and bit 11 (start) set, the size code in bits 8:7 and bit 9 (read) clear.
- R3: A read issues these scans in this order: select address register, shift the address, select control register, shift the start word with bit 9 set, polls, select data register, shift zero while the result is captured, select control register, shift the clear word.
- R4: Each poll shifts CTRL_BASE with bit 17 set. Polling repeats while the returned bit 11 is 1, so k busy replies give k+1 polls.
- R5: After polling ends, the control register is reselected and CTRL_BASE alone is shifted. If the returned bit 10 (error) is 1, the access restarts from the address-register select.
- R6: At most MAX_RETRY restarts are made. If the error is still set after the last attempt, the response has status 1 (device error) and rdata 0. A success has status 0.
- R7: If bit 11 is still 1 in a poll reply that arrives once TIMEOUT_CYC cycles have passed in the poll phase, the access ends with status 2 (timeout) and no clear scan is made. The cycle count restarts with every attempt.
- R8: Write data is replicated by size. Size code 0 (byte) copies bits 7:0 into all four byte lanes. Size code 1 (halfword) copies bits 15:0 into both halves. Size code 2 (word) passes the value unchanged.
- R9: Read data is returned zero-extended. For a byte, address bits 1:0 pick lane 0..3, and lane 0 is bits 7:0. For a halfword, address bit 1 set picks bits 31:16 and clear picks bits 15:0. A word returns all 32 bits.
- R10: `req_ready` falls on acceptance and rises in the same cycle as the one-cycle `rsp_valid` pulse. `scan_req`, `scan_is_sel` and `scan_wdata` stay stable until `scan_ack` arrives. No scan is requested while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | AW | Target byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 device error, 2 timeout |
| rsp_rdata | output | 32 | Read result, zero-extended |
| scan_req | output | 1 | Scan request, held until acknowledged |
| scan_is_sel | output | 1 | 1 register select, 0 data shift |
| scan_wdata | output | 32 | Register code (select) or value to shift |
| scan_ack | input | 1 | Scan complete |
| scan_rdata | input | 32 | Value captured during the shift |

## Verification
The assertions check on every cycle that the scan handshake holds its request steady until it is acknowledged, and that the ready/response handshake stays coherent. They also check that the retry and timeout counters stay within their bounds, and that an error or timeout status never appears unless the matching counter has run out. Only the bench scenarios can show the exact order of the scans, the contents of the start, poll and clear words, and the byte-lane placement of data in both directions. The same holds for the restart on a returned error, the timeout when the start flag never clears, and the reload of the cycle count on each retry. The bench shows these against a behavioural target model across every size and offset.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int DW    = 32;
  localparam int NLANE = DW / 8;
  localparam int LW    = $clog2(NLANE);

  // control word bit positions decoded by the debug port
  localparam int B_EN    = 17;
  localparam int B_START = 11;
  localparam int B_ERR   = 10;
  localparam int B_RD    = 9;
  localparam int B_SZ    = 7;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_DEVERR  = 2'd1;
  localparam logic [1:0] ST_TIMEOUT = 2'd2;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SEL_A, PH_ADDR, PH_SEL_D, PH_WDATA, PH_SEL_C, PH_GO,
    PH_POLL, PH_SEL_RD, PH_RDATA, PH_SEL_CLR, PH_CLR
  } phase_e;
endpackage

// File: rtl/dds_lanes.sv
module dds_lanes import dds_pkg::*; (
  input  logic [1:0]    size,
  input  logic [LW-1:0] addr_lo,
  input  logic [DW-1:0] wr_in,
  output logic [DW-1:0] wr_out,
  input  logic [DW-1:0] rd_in,
  output logic [DW-1:0] rd_out
);
  localparam int HW = DW / 2;

  for (genvar g = 0; g < NLANE; g++) begin : g_wlane
    always_comb begin
      case (size)
        SZ_BYTE: wr_out[8*g +: 8] = wr_in[7:0];
        SZ_HALF: wr_out[8*g +: 8] = wr_in[8*(g % 2) +: 8];
        default: wr_out[8*g +: 8] = wr_in[8*g +: 8];
      endcase
    end
  end

  logic [7:0]    byte_pick;
  logic [HW-1:0] half_pick;

  always_comb begin
    byte_pick = rd_in[8*addr_lo +: 8];
    half_pick = addr_lo[LW-1] ? rd_in[DW-1:HW] : rd_in[HW-1:0];
    case (size)
      SZ_BYTE: rd_out = DW'(byte_pick);
      SZ_HALF: rd_out = DW'(half_pick);
      default: rd_out = rd_in;
    endcase
  end
endmodule

// File: rtl/dds_timeout.sv
module dds_timeout #(
  parameter int LIMIT = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  assign expired = (cnt >= TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end

  AST_TMR_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT)); // R7
  AST_TMR_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(en)); // R7
endmodule

// File: rtl/dds_retry_ctr.sv
module dds_retry_ctr #(
  parameter int MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic has_left
);
  localparam int RW = $clog2(MAX_RETRY + 2);
  logic [RW-1:0] left;

  assign has_left = (left != '0);

  always_ff @(posedge clk) begin
    if (rst)                   left <= '0;
    else if (load)             left <= RW'(MAX_RETRY);
    else if (dec && has_left)  left <= left - 1'b1;
  end

  AST_RETRY_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> has_left); // R6
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    left <= RW'(MAX_RETRY)); // R6
endmodule

// File: rtl/dbg_dma_seq.sv
module dbg_dma_seq import dds_pkg::*; #(
  parameter int              AW          = 32,
  parameter int              IRW         = 5,
  parameter logic [IRW-1:0]  IR_ADDR     = 5'h08,
  parameter logic [IRW-1:0]  IR_DATA     = 5'h09,
  parameter logic [IRW-1:0]  IR_CTRL     = 5'h0A,
  parameter logic [31:0]     CTRL_BASE   = 32'h0000_C000,
  parameter int              TIMEOUT_CYC = 100_000_000,
  parameter int              MAX_RETRY   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_rdata,
  output logic          scan_req,
  output logic          scan_is_sel,
  output logic [DW-1:0] scan_wdata,
  input  logic          scan_ack,
  input  logic [DW-1:0] scan_rdata
);
  localparam logic [DW-1:0] EN_MASK    = DW'(1) << B_EN;
  localparam logic [DW-1:0] START_MASK = DW'(1) << B_START;
  localparam logic [DW-1:0] RD_MASK    = DW'(1) << B_RD;
  localparam logic [DW-1:0] BASE_WORD  = DW'(CTRL_BASE);

  phase_e        state;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_raw;
  logic [DW-1:0] wr_lanes, rd_ext;
  logic          ph_sel;
  logic [DW-1:0] ph_word;
  logic          accept, acked;
  logic          tmo_clr, tmo_en, tmo_exp;
  logic          rty_dec, rty_has;

  assign accept = req_valid && req_ready;
  assign acked  = scan_req && scan_ack;

  dds_lanes u_lanes (
    .size    (size_q),
    .addr_lo (addr_q[LW-1:0]),
    .wr_in   (wdata_q),
    .wr_out  (wr_lanes),
    .rd_in   (rd_raw),
    .rd_out  (rd_ext)
  );

  assign tmo_clr = (state == PH_GO) && acked;
  assign tmo_en  = (state == PH_POLL);

  dds_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmo_clr),
    .en      (tmo_en),
    .expired (tmo_exp)
  );

  assign rty_dec = (state == PH_CLR) && acked && scan_rdata[B_ERR] && rty_has;

  dds_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_rty (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .dec      (rty_dec),
    .has_left (rty_has)
  );

  // what the current phase puts on the scan port
  always_comb begin
    ph_sel  = 1'b0;
    ph_word = '0;
    case (state)
      PH_SEL_A: begin ph_sel = 1'b1; ph_word = DW'(IR_ADDR); end
      PH_ADDR:  ph_word = DW'(addr_q);
      PH_SEL_D, PH_SEL_RD: begin ph_sel = 1'b1; ph_word = DW'(IR_DATA); end
      PH_WDATA: ph_word = wr_lanes;
      PH_SEL_C, PH_SEL_CLR: begin ph_sel = 1'b1; ph_word = DW'(IR_CTRL); end
      PH_GO:    ph_word = BASE_WORD | EN_MASK | START_MASK |
                          (DW'(size_q) << B_SZ) | (write_q ? '0 : RD_MASK);
      PH_POLL:  ph_word = BASE_WORD | EN_MASK;
      PH_CLR:   ph_word = BASE_WORD;
      default:  ph_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_IDLE;
      req_ready   <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_status  <= ST_OK;
      rsp_rdata   <= '0;
      scan_req    <= 1'b0;
      scan_is_sel <= 1'b0;
      scan_wdata  <= '0;
      addr_q      <= '0;
      size_q      <= SZ_WORD;
      write_q     <= 1'b0;
      wdata_q     <= '0;
      rd_raw      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (state == PH_IDLE) begin
        if (accept) begin
          addr_q    <= req_addr;
          size_q    <= req_size;
          write_q   <= req_write;
          wdata_q   <= req_wdata;
          req_ready <= 1'b0;
          state     <= PH_SEL_A;
        end
      end else if (!scan_req) begin
        scan_req    <= 1'b1;
        scan_is_sel <= ph_sel;
        scan_wdata  <= ph_word;
      end else if (scan_ack) begin
        scan_req <= 1'b0;
        case (state)
          PH_SEL_A:   state <= PH_ADDR;
          PH_ADDR:    state <= write_q ? PH_SEL_D : PH_SEL_C;
          PH_SEL_D:   state <= PH_WDATA;
          PH_WDATA:   state <= PH_SEL_C;
          PH_SEL_C:   state <= PH_GO;
          PH_GO:      state <= PH_POLL;
          PH_POLL: begin
            if (scan_rdata[B_START]) begin
              if (tmo_exp) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_TIMEOUT;
                rsp_rdata  <= '0;
                req_ready  <= 1'b1;
                state      <= PH_IDLE;
              end
            end else begin
              state <= write_q ? PH_SEL_CLR : PH_SEL_RD;
            end
          end
          PH_SEL_RD:  state <= PH_RDATA;
          PH_RDATA: begin
            rd_raw <= scan_rdata;
            state  <= PH_SEL_CLR;
          end
          PH_SEL_CLR: state <= PH_CLR;
          PH_CLR: begin
            if (scan_rdata[B_ERR] && rty_has) begin
              state <= PH_SEL_A;
            end else begin
              rsp_valid  <= 1'b1;
              rsp_status <= scan_rdata[B_ERR] ? ST_DEVERR : ST_OK;
              rsp_rdata  <= (scan_rdata[B_ERR] || write_q) ? '0 : rd_ext;
              req_ready  <= 1'b1;
              state      <= PH_IDLE;
            end
          end
          default:    state <= PH_IDLE;
        endcase
      end
    end
  end

  AST_SCAN_HELD: assert property (@(posedge clk) disable iff (rst)
    scan_req && !scan_ack |=> scan_req && $stable(scan_wdata) && $stable(scan_is_sel)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !scan_req); // R10
  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == ST_TIMEOUT |-> $past(tmo_exp)); // R7
  AST_DEVERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == ST_DEVERR |-> $past(!rty_has)); // R6
endmodule

// File: tb/sim_dbg_dma_seq.sv
module sim_dbg_dma_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam int RETRIES = 3;
  localparam logic [31:0] BASE = 32'h0000_C000;
  localparam logic [31:0] C_EN = 32'h0002_0000;
  localparam logic [31:0] C_GO = 32'h0000_0800;
  localparam logic [31:0] C_RD = 32'h0000_0200;
  localparam logic [31:0] IRA = 32'h08, IRD = 32'h09, IRC = 32'h0A;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_size = '0;
  logic req_ready, rsp_valid, scan_req, scan_is_sel;
  logic [1:0] rsp_status;
  logic [31:0] rsp_rdata, scan_wdata;
  logic scan_ack = 1'b0;
  logic [31:0] scan_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // target model
  logic [31:0] mem_m [0:15];
  logic [31:0] ref_m [0:15];
  logic [31:0] areg = '0, dreg = '0;
  logic [4:0] ir = '0;
  int busy_left = 0, nbusy = 0, err_inj = 0;
  bit errflag = 0, acc_wr = 0;
  logic [1:0] acc_sz = '0;
  bit log_sel [0:63];
  logic [31:0] log_dat [0:63];
  int log_n = 0;
  bit exp_sel [0:63];
  logic [31:0] exp_dat [0:63];
  int exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_dma_seq #(.TIMEOUT_CYC(TMO), .MAX_RETRY(RETRIES)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .scan_req(scan_req), .scan_is_sel(scan_is_sel),
    .scan_wdata(scan_wdata), .scan_ack(scan_ack), .scan_rdata(scan_rdata));

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic complete();
    int w;
    w = int'(areg[5:2]);
    if (err_inj > 0) begin
      err_inj--;
      errflag = 1;
    end else if (acc_wr) begin
      case (acc_sz)
        2'd0: mem_m[w][8*areg[1:0] +: 8] = dreg[8*areg[1:0] +: 8];
        2'd1: mem_m[w][16*areg[1] +: 16] = dreg[16*areg[1] +: 16];
        default: mem_m[w] = dreg;
      endcase
    end else begin
      dreg = mem_m[w];
    end
  endtask

  // scan responder
  initial begin
    logic [31:0] ret;
    forever begin
      @(negedge clk);
      if (scan_req && !scan_ack) begin
        repeat (log_n % 3) @(negedge clk);
        ret = '0;
        if (log_n < 64) begin
          log_sel[log_n] = scan_is_sel;
          log_dat[log_n] = scan_wdata;
          log_n++;
        end
        if (scan_is_sel) ir = scan_wdata[4:0];
        else if (32'(ir) == IRA) begin ret = areg; areg = scan_wdata; end
        else if (32'(ir) == IRD) begin ret = dreg; dreg = scan_wdata; end
        else if (32'(ir) == IRC) begin
          ret = ((busy_left > 0) ? C_GO : 32'h0) | (errflag ? 32'h400 : 32'h0);
          if (scan_wdata[17]) begin
            if (scan_wdata[11] && busy_left == 0) begin
              acc_wr = !scan_wdata[9];
              acc_sz = scan_wdata[8:7];
              busy_left = nbusy;
              if (nbusy == 0) complete();
            end else if (busy_left > 0) begin
              busy_left--;
              if (busy_left == 0) complete();
            end
          end else errflag = 0;
        end
        scan_ack = 1'b1;
        scan_rdata = ret;
        @(negedge clk);
        scan_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      report();
    end
  end

  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [1:0] st, output logic [31:0] rd);
    bit busy_ok;
    log_n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    st = rsp_status;
    rd = rsp_rdata;
    chk(busy_ok, "R10 ready low while busy", 32'(busy_ok), 32'h1);
  endtask

  task automatic push(input bit s, input logic [31:0] d);
    exp_sel[exp_n] = s; exp_dat[exp_n] = d; exp_n++;
  endtask

  task automatic build(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] rep, input int k);
    exp_n = 0;
    push(1, IRA); push(0, a);
    if (wr) begin push(1, IRD); push(0, rep); end
    push(1, IRC);
    push(0, BASE | C_EN | C_GO | (32'(sz) << 7) | (wr ? 32'h0 : C_RD));
    for (int i = 0; i <= k; i++) push(0, BASE | C_EN);
    if (!wr) begin push(1, IRD); push(0, 32'h0); end
    push(1, IRC); push(0, BASE);
  endtask

  task automatic cmp_log(input string req);
    bit ok;
    int bad;
    ok = (log_n == exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_sel[i] != exp_sel[i] || log_dat[i] !== exp_dat[i])) bad = i;
    if (bad >= 0) ok = 0;
    if (bad >= 0) chk(ok, req, log_dat[bad], exp_dat[bad]);
    else chk(ok, req, 32'(log_n), 32'(exp_n));
  endtask

  function automatic int count_addr_sel();
    int n = 0;
    for (int i = 0; i < log_n; i++) if (log_sel[i] && log_dat[i] == IRA) n++;
    return n;
  endfunction

  function automatic logic [31:0] rep_of(input logic [1:0] sz, input logic [31:0] v);
    if (sz == 2'd0) return {4{v[7:0]}};
    if (sz == 2'd1) return {2{v[15:0]}};
    return v;
  endfunction

  initial begin
    logic [1:0] st;
    logic [31:0] rd, a, v, exp;
    int step;
    for (int i = 0; i < 16; i++) begin mem_m[i] = '0; ref_m[i] = '0; end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
    chk(scan_req == 1'b0, "R1 no scan after reset", 32'(scan_req), 32'h0);

    // write sweep over sizes and offsets
    step = 0;
    for (int w = 1; w <= 2; w++)
      for (int sz = 2; sz >= 0; sz--)
        for (int off = 0; off < 4; off += (1 << sz)) begin
          a = 32'(w * 4 + off);
          v = 32'h5A3C_9600 + 32'(w) * 32'h0100_0000 + 32'(off) * 32'h0001_0011 + 32'(sz) * 32'h10 + 32'(step);
          nbusy = step % 3;
          access(1, 2'(sz), a, v, st, rd);
          chk(st == 2'd0, "R6 write status ok", 32'(st), 32'h0);
          build(1, 2'(sz), a, rep_of(2'(sz), v), nbusy);
          cmp_log("R2 R4 R5 R8 write scan order and words");
          case (sz)
            0: ref_m[w][8*off +: 8] = v[7:0];
            1: ref_m[w][16*(off/2) +: 16] = v[15:0];
            default: ref_m[w] = v;
          endcase
          chk(mem_m[w] === ref_m[w], "R8 lane written in target", mem_m[w], ref_m[w]);
          step++;
        end

    // read sweep
    for (int w = 1; w <= 2; w++)
      for (int sz = 0; sz <= 2; sz++)
        for (int off = 0; off < 4; off += (1 << sz)) begin
          a = 32'(w * 4 + off);
          nbusy = step % 4;
          access(0, 2'(sz), a, 32'h0, st, rd);
          if (sz == 0) exp = 32'(ref_m[w][8*off +: 8]);
          else if (sz == 1) exp = 32'(ref_m[w][16*(off/2) +: 16]);
          else exp = ref_m[w];
          chk(rd === exp, "R9 read lane select", rd, exp);
          chk(st == 2'd0, "R6 read status ok", 32'(st), 32'h0);
          build(0, 2'(sz), a, 32'h0, nbusy);
          cmp_log("R3 R4 read scan order and words");
          step++;
        end

    // retries that end in success
    nbusy = 0; err_inj = 2;
    access(1, 2'd2, 32'h0C, 32'hDEAD_BEEF, st, rd);
    chk(st == 2'd0, "R6 ok after two errors", 32'(st), 32'h0);
    chk(count_addr_sel() == 3, "R5 restart from address select", 32'(count_addr_sel()), 32'h3);
    chk(mem_m[3] === 32'hDEAD_BEEF, "R5 write lands after retry", mem_m[3], 32'hDEAD_BEEF);
    err_inj = 1;
    access(0, 2'd1, 32'h0E, 32'h0, st, rd);
    chk(rd === 32'h0000_DEAD, "R5 R9 read after retry", rd, 32'h0000_DEAD);
    chk(count_addr_sel() == 2, "R5 read restarts once", 32'(count_addr_sel()), 32'h2);

    // retries exhausted
    err_inj = RETRIES + 1;
    access(1, 2'd2, 32'h10, 32'h1234_5678, st, rd);
    chk(st == 2'd1, "R6 device error after limit", 32'(st), 32'h1);
    chk(count_addr_sel() == RETRIES + 1, "R6 attempt count", 32'(count_addr_sel()), 32'(RETRIES + 1));
    chk(mem_m[4] === 32'h0, "R6 failed write leaves target", mem_m[4], 32'h0);
    err_inj = 0;

    // timer reloaded on each attempt: 3 attempts x 6 polls exceeds one window
    nbusy = 5; err_inj = 2;
    access(0, 2'd2, 32'h0C, 32'h0, st, rd);
    chk(st == 2'd0, "R7 timer reloads per retry", 32'(st), 32'h0);
    chk(rd === 32'hDEAD_BEEF, "R7 data after slow retries", rd, 32'hDEAD_BEEF);

    // timeout
    nbusy = 1000; err_inj = 0;
    access(0, 2'd2, 32'h04, 32'h0, st, rd);
    chk(st == 2'd2, "R7 timeout status", 32'(st), 32'h2);
    chk(log_dat[log_n-1] === (BASE | C_EN) && !log_sel[log_n-1], "R7 no clear scan after timeout",
        log_dat[log_n-1], BASE | C_EN);
    chk(rd === 32'h0, "R7 timeout rdata zero", rd, 32'h0);
    busy_left = 0; errflag = 0; nbusy = 1;
    access(0, 2'd2, 32'h04, 32'h0, st, rd);
    chk(st == 2'd0 && rd === ref_m[1], "R7 recovery after timeout", rd, ref_m[1]);

    done = 1;
    report();
  end
endmodule